// File: doc/BRIEF.md
# Binary-Search Multiplier Divider

This block divides one unsigned integer by another without a shift-and-subtract partial-remainder loop. The quotient is found by binary search over its own range. The search starts at the most significant quotient bit and works down to bit zero. At each step a trial quotient is formed: the bits already settled, plus the candidate bit set. The trial is multiplied by the divisor on a single shared multiplier. The candidate bit stays set only if the product does not exceed the dividend. When a bit is kept, the dividend minus that product becomes the running remainder.

A caller presents both operands with a one-cycle `start` while `busy` is low. The block then runs a fixed number of cycles, whatever the operand values. It ends with a one-cycle `done` pulse, and the quotient, remainder and divide-by-zero flag are then valid. These results stay on the outputs until the next division finishes. A zero divisor is not treated as a special path. Every product is zero, so every trial bit is kept.

Top module: `bsearch_div`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `quotient`, `remainder` and `div_by_zero` are all zero.
- R2: For a nonzero divisor, `quotient` is the floor of dividend / divisor and `remainder` is dividend minus quotient times divisor, which is less than the divisor.
- R3: `done` is high for exactly one cycle, W+1 clock edges after the edge that accepted `start`. `busy` is high from the edge after acceptance until `done` rises, and low while `done` is high. The count is the same for every operand pair.
- R4: A `start` pulse while `busy` is high is ignored. The running division finishes with its own operands and its own timing.
- R5: A zero divisor gives an all-ones quotient, a remainder equal to the dividend and `div_by_zero` = 1, with the same latency as R3.
- R6: `quotient`, `remainder` and `div_by_zero` keep their values from one `done` pulse to the next. Operand changes without an accepted `start` leave them unchanged.
- R7: A `start` presented in the cycle where `done` is high is accepted. A following division with a nonzero divisor clears `div_by_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a division, sampled when busy is low |
| dividend_i | input | W | Unsigned dividend |
| divisor_i | input | W | Unsigned divisor |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | W | Registered quotient |
| remainder | output | W | Registered remainder |
| div_by_zero | output | 1 | Last finished division had a zero divisor |

## Verification
The bench drives inputs and samples outputs on the falling edge. After the falling edge on which `start` drops, it counts falling edges until `done` appears and expects exactly W+1. The results are compared in that same cycle, when `done` is first seen. Hold behaviour is checked several cycles after `done`, with the operands changed and no new `start`. The checker module counts busy edges from acceptance. It requires `done` to appear on edge W+1, and the operands it captured to match the results at that point.

// File: rtl/bsdiv_pkg.sv
package bsdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_FINISH = 2'd2
  } bsdiv_state_e;

  function automatic int unsigned idx_width(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/bsdiv_ctrl.sv
module bsdiv_ctrl
  import bsdiv_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = idx_width(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          busy,
  output logic          load,
  output logic          step,
  output logic          finish,
  output logic [IW-1:0] bit_idx
);
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  bsdiv_state_e state_q;

  assign busy   = (state_q != ST_IDLE);
  assign load   = (state_q == ST_IDLE) && start;
  assign step   = (state_q == ST_SEARCH);
  assign finish = (state_q == ST_FINISH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_idx <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_SEARCH;
          bit_idx <= TOP_IDX;
        end
        ST_SEARCH: begin
          if (bit_idx == '0) state_q <= ST_FINISH;
          else               bit_idx <= bit_idx - 1'b1;
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bsdiv_trial.sv
module bsdiv_trial
  import bsdiv_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = idx_width(W)
) (
  input  logic [W-1:0]  acc,
  input  logic [IW-1:0] bit_idx,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  output logic          keep,
  output logic [W-1:0]  trial,
  output logic [W-1:0]  trial_rem
);
  localparam int PW = 2 * W;

  logic [W-1:0]  bit_mask;
  logic [PW-1:0] product;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign bit_mask[i] = (bit_idx == IW'(i));
  end

  assign trial     = acc | bit_mask;
  assign product   = {{W{1'b0}}, trial} * {{W{1'b0}}, divisor};
  assign keep      = (product <= {{W{1'b0}}, dividend});
  assign trial_rem = dividend - product[W-1:0];
endmodule

// File: rtl/bsearch_div.sv
module bsearch_div
  import bsdiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  localparam int IW = idx_width(W);

  logic          load, step, finish, keep;
  logic [IW-1:0] bit_idx;
  logic [W-1:0]  dvd_q, dsr_q, acc_q, rem_q;
  logic [W-1:0]  trial, trial_rem;

  bsdiv_ctrl #(.W(W), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .load(load),
    .step(step), .finish(finish), .bit_idx(bit_idx)
  );

  bsdiv_trial #(.W(W), .IW(IW)) u_trial (
    .acc(acc_q), .bit_idx(bit_idx), .dividend(dvd_q), .divisor(dsr_q),
    .keep(keep), .trial(trial), .trial_rem(trial_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dvd_q <= '0;
      dsr_q <= '0;
      acc_q <= '0;
      rem_q <= '0;
    end else if (load) begin
      dvd_q <= dividend_i;
      dsr_q <= divisor_i;
      acc_q <= '0;
      rem_q <= dividend_i;
    end else if (step && keep) begin
      acc_q <= trial;
      rem_q <= trial_rem;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        quotient    <= acc_q;
        remainder   <= rem_q;
        div_by_zero <= (dsr_q == '0);
      end
    end
  end
endmodule

// File: rtl/bsdiv_chk.sv
module bsdiv_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [W-1:0] dividend_i,
  input logic [W-1:0] divisor_i,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         div_by_zero
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W + 3) + 1;

  logic [CW-1:0] edge_cnt;
  logic [W-1:0]  cap_dvd, cap_dsr;
  logic [PW-1:0] recon;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cnt <= '0;
      cap_dvd  <= '0;
      cap_dsr  <= '0;
    end else if (start && !busy) begin
      edge_cnt <= '0;
      cap_dvd  <= dividend_i;
      cap_dsr  <= divisor_i;
    end else if (busy) begin
      edge_cnt <= edge_cnt + 1'b1;
    end
  end

  assign recon = {{W{1'b0}}, quotient} * {{W{1'b0}}, cap_dsr} + {{W{1'b0}}, remainder};

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy && !done && quotient == '0 && !div_by_zero)); // R1
  AST_RECON: assert property (@(posedge clk) disable iff (rst) (done && cap_dsr != '0) |-> (recon == {{W{1'b0}}, cap_dvd})); // R2
  AST_REM_SMALL: assert property (@(posedge clk) disable iff (rst) (done && cap_dsr != '0) |-> (remainder < cap_dsr)); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst) done |-> (edge_cnt == CW'(W + 1))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R3
  AST_ACCEPT: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy); // R3
  AST_ZERO_DIV: assert property (@(posedge clk) disable iff (rst) (done && cap_dsr == '0) |-> (div_by_zero && quotient == '1 && remainder == cap_dvd)); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero))); // R6
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst) (done && cap_dsr != '0) |-> !div_by_zero); // R7
endmodule

bind bsearch_div bsdiv_chk #(.W(W)) u_chk (.*);

// File: tb/test_bsearch_div.sv
module test_bsearch_div;
  localparam int W = 16;
  localparam logic [W-1:0] ONES = '1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dividend_i = '0, divisor_i = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  bsearch_div #(.W(W)) i_bsearch_div (
    .clk(clk), .rst(rst), .start(start), .dividend_i(dividend_i),
    .divisor_i(divisor_i), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Pulse start on a falling edge, count falling edges until done; results checked when done is seen.
  task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, output int lat);
    @(negedge clk);
    dividend_i = a; divisor_i = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "quotient", quotient, 0);
    check("R1", "remainder", remainder, 0);
    check("R1", "flag", div_by_zero, 0);
  endtask

  task automatic t_normal(input logic [W-1:0] a, input logic [W-1:0] b);
    int lat;
    run_div(a, b, lat);
    check("R3", "latency", lat, W + 1);
    check("R3", "busy low at done", busy, 0);
    check("R2", "quotient", quotient, a / b);
    check("R2", "remainder", remainder, a % b);
    check("R7", "flag clear", div_by_zero, 0);
    @(negedge clk);
    check("R3", "done one cycle", done, 0);
  endtask

  task automatic t_zero(input logic [W-1:0] a);
    int lat;
    run_div(a, '0, lat);
    check("R5", "latency", lat, W + 1);
    check("R5", "quotient ones", quotient, ONES);
    check("R5", "remainder", remainder, a);
    check("R5", "flag", div_by_zero, 1);
  endtask

  task automatic t_busy_ignore();
    int lat;
    @(negedge clk);
    dividend_i = 16'd5000; divisor_i = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (4) begin @(negedge clk); lat++; end
    dividend_i = 16'd9; divisor_i = 16'd0; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check("R4", "latency", lat, W + 1);
    check("R4", "quotient", quotient, 5000 / 7);
    check("R4", "remainder", remainder, 5000 % 7);
    check("R4", "flag", div_by_zero, 0);
    repeat (W + 4) @(negedge clk);
    check("R4", "no second done", done, 0);
    check("R4", "idle", busy, 0);
  endtask

  task automatic t_hold();
    int lat;
    run_div(16'd1234, 16'd10, lat);
    dividend_i = 16'd7; divisor_i = 16'd3;
    repeat (W + 5) @(negedge clk);
    check("R6", "done low", done, 0);
    check("R6", "quotient held", quotient, 123);
    check("R6", "remainder held", remainder, 4);
  endtask

  task automatic t_back_to_back();
    int lat;
    run_div(16'd100, 16'd0, lat);
    check("R7", "first flag", div_by_zero, 1);
    dividend_i = 16'd100; divisor_i = 16'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7", "accepted in done cycle", busy, 1);
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    check("R7", "latency", lat, W + 1);
    check("R7", "quotient", quotient, 11);
    check("R7", "remainder", remainder, 1);
    check("R7", "flag cleared", div_by_zero, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal(16'd1000, 16'd7);
    t_normal(16'd144, 16'd12);
    t_normal(16'd65535, 16'd1);
    t_normal(16'd65535, 16'd65535);
    t_normal(16'd3, 16'd200);
    t_normal(16'd0, 16'd5);
    t_normal(16'd65534, 16'd255);
    t_normal(16'd40000, 16'd3);
    t_zero(16'd777);
    t_zero(16'd0);
    t_busy_ignore();
    t_hold();
    t_back_to_back();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule